// File: doc/BRIEF.md
# Addressed Two-Wire Wiper Register Slave

This block is a slave on a two-wire serial bus (SCL clock, SDA data, SDA open-drain). It runs on the system clock and holds four 6-bit wiper position registers. The two bus lines are synchronized and oversampled. START and STOP are found from SDA edges while SCL is high. The first byte after a START is a control byte. It carries a fixed device code, a 3-bit address compared against strap pins, and a direction bit. The slave drives SDA only through a pull-low enable, `sda_pull_o`. The board or bench forms the wired-AND of the master's drive and this enable.

A write transfer may carry any number of data bytes. Each data byte names its own channel and position, so channels can be loaded in any order. A read transfer returns the channels in order, starting at channel 0 and wrapping after channel 3. It keeps going for as long as the master acknowledges. The system clock must run at least ten times faster than a 400 kHz bus.

States:
- `ST_IDLE`: bus free.
- `ST_CTRL`: shifting the control byte.
- `ST_CTRL_ACK`: acknowledging a matched control byte.
- `ST_WR_DATA` / `ST_WR_ACK`: receiving a data byte / acknowledging it.
- `ST_RD_DATA` / `ST_RD_ACK`: sending a byte / sampling the master's answer.
- `ST_WAIT`: bus released until the next START.

Transitions:
- A START goes to `ST_CTRL` from any state.
- A STOP goes to `ST_IDLE` from any state.
- `ST_CTRL` goes to `ST_CTRL_ACK` on a match, or to `ST_WAIT` on a mismatch, at the eighth SCL fall.
- `ST_CTRL_ACK` goes to `ST_RD_DATA` or `ST_WR_DATA`, chosen by the direction bit.
- `ST_WR_DATA` and `ST_WR_ACK` alternate.
- `ST_RD_DATA` goes to `ST_RD_ACK`.
- `ST_RD_ACK` goes back to `ST_RD_DATA` on an acknowledge, or to `ST_WAIT` on a not-acknowledge.

Top module: `twi_wiper_slave`

## Requirements
- R1: Reset sets all four wiper registers to 32 and leaves `sda_pull_o` low (SDA released). This holds whether or not a transfer is in progress.
- R2: A START (SDA falling while SCL is high) begins decoding a new control byte. A STOP (SDA rising while SCL is high) returns the slave to idle. Bytes clocked after a STOP without a new START are not acknowledged.
- R3: Bits are taken MSB first. The control byte has bits [7:4] = 4'b0101, bits [3:1] equal to `addr_i[2:0]`, and bit 0 = 1 for read or 0 for write. A matching control byte is acknowledged by pulling SDA low through the high phase of the ninth clock.
- R4: A control byte whose device code or address differs is not acknowledged. All following bytes are ignored, with no acknowledge and no register change, until the next START.
- R5: In a write transfer, each data byte uses bits [7:6] as the channel and bits [5:0] as the position. The position is committed after the eighth bit, and the byte is acknowledged.
- R6: Any number of data bytes may follow one write control byte, addressing channels in any order.
- R7: In a read transfer, each returned byte is {channel[1:0], position[5:0]}, sent MSB first. Channel 0 comes first, then channels in ascending order, wrapping from 3 back to 0.
- R8: After the master answers a read byte with not-acknowledge, the slave keeps SDA released (reads as all ones) until the next START.
- R9: A repeated START in the middle of a transfer abandons any partly received byte without committing it, then decodes a new control byte.
- R10: `sda_pull_o` changes only while the synchronized SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level (wired-AND result) |
| addr_i | input | 3 | Strap address compared with control bits [3:1] |
| sda_pull_o | output | 1 | 1 = pull SDA low, 0 = release |
| wiper_o | output | 24 | Wiper positions, channel c at bits [6c+5:6c] |

## Verification
The hardest situations to reach from the ports are a repeated START arriving partway through a data byte, and a read that runs past channel 3. In both, the slave must change direction or abandon a byte at an exact SCL edge. The bench master produces them directly. It emits a START after four data bits of a write, then confirms that the target wiper kept its old value. It also acknowledges four read bytes and then takes a fifth, which must be channel 0 again. After a not-acknowledge, the master clocks a further byte with SDA released and expects all ones, which shows the slave no longer drives the line.

// File: rtl/twi_wiper_pkg.sv
package twi_wiper_pkg;
    localparam int NUM_CH    = 4;
    localparam int POS_W     = 6;
    localparam int CH_W      = $clog2(NUM_CH);
    localparam int BYTE_W    = CH_W + POS_W;
    localparam int ADDR_W    = 3;
    localparam int CODE_W    = BYTE_W - ADDR_W - 1;
    localparam logic [CODE_W-1:0] DEV_CODE = 4'b0101;
    localparam logic [POS_W-1:0]  RESET_POS = 6'd32;
    localparam int CNT_W     = $clog2(BYTE_W + 1);

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CTRL,
        ST_CTRL_ACK,
        ST_WR_DATA,
        ST_WR_ACK,
        ST_RD_DATA,
        ST_RD_ACK,
        ST_WAIT
    } bus_state_t;
endpackage

// File: rtl/twi_line_sync.sv
module twi_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_o,
    output logic scl_rise_o,
    output logic scl_fall_o,
    output logic sda_o,
    output logic start_o,
    output logic stop_o
);
    logic [STAGES-1:0] scl_chain;
    logic [STAGES-1:0] sda_chain;
    logic              scl_prev;
    logic              sda_prev;

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    scl_chain[s] <= 1'b1;
                    sda_chain[s] <= 1'b1;
                end else if (s == 0) begin
                    scl_chain[s] <= scl_i;
                    sda_chain[s] <= sda_i;
                end else begin
                    scl_chain[s] <= scl_chain[s-1];
                    sda_chain[s] <= sda_chain[s-1];
                end
            end
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_prev <= 1'b1;
            sda_prev <= 1'b1;
        end else begin
            scl_prev <= scl_chain[STAGES-1];
            sda_prev <= sda_chain[STAGES-1];
        end
    end

    assign scl_o      = scl_chain[STAGES-1];
    assign sda_o      = sda_chain[STAGES-1];
    assign scl_rise_o = scl_o & ~scl_prev;
    assign scl_fall_o = ~scl_o & scl_prev;
    assign start_o    = scl_o & scl_prev & sda_prev & ~sda_o;
    assign stop_o     = scl_o & scl_prev & ~sda_prev & sda_o;
endmodule

// File: rtl/twi_wiper_bank.sv
module twi_wiper_bank
    import twi_wiper_pkg::*;
(
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    wr_en_i,
    input  logic [CH_W-1:0]         wr_ch_i,
    input  logic [POS_W-1:0]        wr_pos_i,
    output logic [NUM_CH*POS_W-1:0] wiper_o
);
    generate
        for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)
                    wiper_o[c*POS_W +: POS_W] <= RESET_POS;
                else if (wr_en_i && wr_ch_i == CH_W'(c))
                    wiper_o[c*POS_W +: POS_W] <= wr_pos_i;
            end
        end
    endgenerate

    AST_WIPER_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en_i |=> $stable(wiper_o)); // R5
endmodule

// File: rtl/twi_wiper_slave.sv
module twi_wiper_slave
    import twi_wiper_pkg::*;
(
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    scl_i,
    input  logic                    sda_i,
    input  logic [ADDR_W-1:0]       addr_i,
    output logic                    sda_pull_o,
    output logic [NUM_CH*POS_W-1:0] wiper_o
);
    bus_state_t        state, state_nx;
    logic              scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
    logic [BYTE_W-1:0] rx_sh, tx_sh;
    logic [CNT_W-1:0]  bit_cnt;
    logic [CH_W-1:0]   rd_ch;
    logic              mack;
    logic              byte_end, ctrl_match, wr_en;

    twi_line_sync #(.STAGES(2)) i_sync (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
        .scl_o(scl_s), .scl_rise_o(scl_rise), .scl_fall_o(scl_fall),
        .sda_o(sda_s), .start_o(start_det), .stop_o(stop_det)
    );

    twi_wiper_bank i_bank (
        .clk(clk), .rst_n(rst_n), .wr_en_i(wr_en),
        .wr_ch_i(rx_sh[BYTE_W-1 -: CH_W]), .wr_pos_i(rx_sh[POS_W-1:0]),
        .wiper_o(wiper_o)
    );

    function automatic logic [BYTE_W-1:0] rd_byte(input logic [CH_W-1:0] ch,
                                                  input logic [NUM_CH*POS_W-1:0] w);
        return {ch, w[ch*POS_W +: POS_W]};
    endfunction

    assign byte_end   = scl_fall && (bit_cnt == CNT_W'(BYTE_W));
    assign ctrl_match = (rx_sh[BYTE_W-1 -: CODE_W] == DEV_CODE) &&
                        (rx_sh[ADDR_W:1] == addr_i);
    assign wr_en      = (state == ST_WR_DATA) && byte_end && !start_det && !stop_det;

    // next-state logic
    always_comb begin
        state_nx = state;
        if (start_det)
            state_nx = ST_CTRL;
        else if (stop_det)
            state_nx = ST_IDLE;
        else begin
            unique case (state)
                ST_IDLE:     state_nx = ST_IDLE;
                ST_CTRL:     if (byte_end) state_nx = ctrl_match ? ST_CTRL_ACK : ST_WAIT;
                ST_CTRL_ACK: if (scl_fall) state_nx = rx_sh[0] ? ST_RD_DATA : ST_WR_DATA;
                ST_WR_DATA:  if (byte_end) state_nx = ST_WR_ACK;
                ST_WR_ACK:   if (scl_fall) state_nx = ST_WR_DATA;
                ST_RD_DATA:  if (byte_end) state_nx = ST_RD_ACK;
                ST_RD_ACK:   if (scl_fall) state_nx = mack ? ST_RD_DATA : ST_WAIT;
                ST_WAIT:     state_nx = ST_WAIT;
                default:     state_nx = ST_IDLE;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // outputs and datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sda_pull_o <= 1'b0;
            bit_cnt    <= '0;
            rx_sh      <= '0;
            tx_sh      <= '0;
            rd_ch      <= '0;
            mack       <= 1'b0;
        end else if (start_det || stop_det) begin
            sda_pull_o <= 1'b0;
            bit_cnt    <= '0;
        end else begin
            unique case (state)
                ST_CTRL, ST_WR_DATA: begin
                    if (scl_rise) begin
                        rx_sh   <= {rx_sh[BYTE_W-2:0], sda_s};
                        bit_cnt <= bit_cnt + 1'b1;
                    end else if (byte_end) begin
                        bit_cnt    <= '0;
                        sda_pull_o <= (state == ST_WR_DATA) || ctrl_match;
                    end
                end
                ST_CTRL_ACK: begin
                    if (scl_fall) begin
                        if (rx_sh[0]) begin
                            rd_ch      <= '0;
                            tx_sh      <= rd_byte('0, wiper_o);
                            sda_pull_o <= ~rd_byte('0, wiper_o)[BYTE_W-1];
                        end else begin
                            sda_pull_o <= 1'b0;
                        end
                    end
                end
                ST_WR_ACK: begin
                    if (scl_fall) sda_pull_o <= 1'b0;
                end
                ST_RD_DATA: begin
                    if (scl_rise) begin
                        bit_cnt <= bit_cnt + 1'b1;
                    end else if (byte_end) begin
                        bit_cnt    <= '0;
                        sda_pull_o <= 1'b0;
                    end else if (scl_fall) begin
                        tx_sh      <= {tx_sh[BYTE_W-2:0], 1'b0};
                        sda_pull_o <= ~tx_sh[BYTE_W-2];
                    end
                end
                ST_RD_ACK: begin
                    if (scl_rise) begin
                        mack <= ~sda_s;
                    end else if (scl_fall && mack) begin
                        rd_ch      <= rd_ch + 1'b1;
                        tx_sh      <= rd_byte(rd_ch + 1'b1, wiper_o);
                        sda_pull_o <= ~rd_byte(rd_ch + 1'b1, wiper_o)[BYTE_W-1];
                    end
                end
                ST_IDLE, ST_WAIT: sda_pull_o <= 1'b0;
                default:          sda_pull_o <= 1'b0;
            endcase
        end
    end

    AST_PULL_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (scl_s && $past(scl_s)) |-> $stable(sda_pull_o)); // R10
    AST_CTRL_ACK_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_CTRL_ACK) |-> ctrl_match); // R3
    AST_RELEASED_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE || state == ST_WAIT) |-> !sda_pull_o); // R4
    AST_BIT_CNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        bit_cnt <= CNT_W'(BYTE_W)); // R5
    AST_START_RESTARTS: assert property (@(posedge clk) disable iff (!rst_n)
        start_det |=> (state == ST_CTRL && bit_cnt == '0)); // R9
endmodule

// File: tb/test_twi_wiper_slave.sv
module test_twi_wiper_slave;
    localparam int CLK_PERIOD = 10;
    localparam int QTR = 10;
    localparam logic [2:0] MY_ADDR = 3'b101;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        scl = 1'b1;
    logic        sda_m = 1'b1;
    logic        sda_pull;
    logic        sda_line;
    logic [23:0] wiper;

    int n_vec = 0;
    int n_bad = 0;
    logic [7:0] exp_q[$];
    logic [7:0] got_byte;
    event       byte_ev;

    assign sda_line = sda_m & ~sda_pull;

    always #(CLK_PERIOD/2) clk = ~clk;

    twi_wiper_slave i_twi_wiper_slave (
        .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_line),
        .addr_i(MY_ADDR), .sda_pull_o(sda_pull), .wiper_o(wiper)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_vec++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic waitc(input int n);
        repeat (n) @(negedge clk);
    endtask

    function automatic int wp(input int c);
        return int'(wiper[c*6 +: 6]);
    endfunction

    task automatic bus_start();
        sda_m = 1'b1; waitc(QTR);
        scl = 1'b1;   waitc(2*QTR);
        sda_m = 1'b0; waitc(2*QTR);
        scl = 1'b0;   waitc(QTR);
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; waitc(QTR);
        scl = 1'b1;   waitc(2*QTR);
        sda_m = 1'b1; waitc(2*QTR);
    endtask

    task automatic send_bit(input logic b);
        sda_m = b; waitc(QTR);
        scl = 1'b1; waitc(2*QTR);
        scl = 1'b0; waitc(QTR);
    endtask

    task automatic send_byte(input logic [7:0] b, output logic acked);
        for (int i = 7; i >= 0; i--) send_bit(b[i]);
        sda_m = 1'b1; waitc(QTR);
        scl = 1'b1; waitc(QTR);
        acked = ~sda_line;
        waitc(QTR);
        scl = 1'b0; waitc(QTR);
    endtask

    task automatic recv_byte(input bit give_ack, input bit scored, output logic [7:0] b);
        for (int i = 7; i >= 0; i--) begin
            sda_m = 1'b1; waitc(QTR);
            scl = 1'b1; waitc(QTR);
            b[i] = sda_line;
            waitc(QTR);
            scl = 1'b0; waitc(QTR);
        end
        sda_m = ~give_ack; waitc(QTR);
        scl = 1'b1; waitc(2*QTR);
        scl = 1'b0; waitc(QTR);
        sda_m = 1'b1;
        if (scored) begin
            got_byte = b;
            -> byte_ev;
        end
    endtask

    // scoreboard monitor: compares each scored read byte against the queue
    initial begin
        forever begin
            @(byte_ev);
            if (exp_q.size() == 0)
                check(1'b0, "R7 unexpected byte", int'(got_byte), -1);
            else begin
                logic [7:0] e;
                e = exp_q.pop_front();
                check(got_byte == e, "R7 read byte", int'(got_byte), int'(e));
            end
        end
    end

    initial begin
        waitc(150000);
        check(1'b0, "watchdog", 0, 1);
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        logic       ak;
        logic [7:0] rb;
        waitc(5);
        // R1 reset state
        for (int c = 0; c < 4; c++) check(wp(c) == 32, "R1 reset wiper", wp(c), 32);
        check(sda_pull == 1'b0, "R1 reset release", int'(sda_pull), 0);
        rst_n = 1'b1;
        waitc(5);

        // R3 / R5 single write
        bus_start();
        send_byte({4'b0101, MY_ADDR, 1'b0}, ak);
        check(ak == 1'b1, "R3 control ack", int'(ak), 1);
        send_byte({2'd2, 6'd17}, ak);
        check(ak == 1'b1, "R5 data ack", int'(ak), 1);
        bus_stop();
        check(wp(2) == 17, "R5 commit ch2", wp(2), 17);
        check(wp(0) == 32 && wp(1) == 32 && wp(3) == 32, "R5 others kept", wp(0), 32);

        // R6 multi-byte out of order
        bus_start();
        send_byte({4'b0101, MY_ADDR, 1'b0}, ak);
        send_byte({2'd3, 6'd63}, ak);
        check(ak == 1'b1, "R6 ack byte1", int'(ak), 1);
        send_byte({2'd0, 6'd0}, ak);
        send_byte({2'd1, 6'd5}, ak);
        check(ak == 1'b1, "R6 ack byte3", int'(ak), 1);
        bus_stop();
        check(wp(3) == 63, "R6 ch3", wp(3), 63);
        check(wp(0) == 0, "R6 ch0", wp(0), 0);
        check(wp(1) == 5, "R6 ch1", wp(1), 5);

        // R4 address mismatch
        bus_start();
        send_byte({4'b0101, 3'b100, 1'b0}, ak);
        check(ak == 1'b0, "R4 wrong address nack", int'(ak), 0);
        send_byte({2'd1, 6'd44}, ak);
        check(ak == 1'b0, "R4 data ignored nack", int'(ak), 0);
        bus_stop();
        check(wp(1) == 5, "R4 ch1 unchanged", wp(1), 5);
        // R4 device code mismatch
        bus_start();
        send_byte({4'b0110, MY_ADDR, 1'b0}, ak);
        check(ak == 1'b0, "R4 wrong code nack", int'(ak), 0);
        bus_stop();

        // R2 bytes after STOP without START are ignored
        send_byte({4'b0101, MY_ADDR, 1'b0}, ak);
        check(ak == 1'b0, "R2 no start no ack", int'(ak), 0);
        bus_stop();

        // R7 read with wrap, R8 release after nack
        exp_q.push_back({2'd0, 6'd0});
        exp_q.push_back({2'd1, 6'd5});
        exp_q.push_back({2'd2, 6'd17});
        exp_q.push_back({2'd3, 6'd63});
        exp_q.push_back({2'd0, 6'd0});
        bus_start();
        send_byte({4'b0101, MY_ADDR, 1'b1}, ak);
        check(ak == 1'b1, "R3 read control ack", int'(ak), 1);
        for (int k = 0; k < 5; k++) recv_byte(k < 4, 1'b1, rb);
        check(sda_pull == 1'b0, "R8 released after nack", int'(sda_pull), 0);
        recv_byte(1'b0, 1'b0, rb);
        check(rb == 8'hFF, "R8 no further data", int'(rb), 255);
        bus_stop();
        check(exp_q.size() == 0, "R7 all bytes read", exp_q.size(), 0);

        // R9 repeated START: write then read in one bus hold
        bus_start();
        send_byte({4'b0101, MY_ADDR, 1'b0}, ak);
        send_byte({2'd0, 6'd9}, ak);
        exp_q.push_back({2'd0, 6'd9});
        bus_start();
        send_byte({4'b0101, MY_ADDR, 1'b1}, ak);
        check(ak == 1'b1, "R9 restart read ack", int'(ak), 1);
        recv_byte(1'b0, 1'b1, rb);
        bus_stop();

        // R9 partial byte abandoned by repeated START
        bus_start();
        send_byte({4'b0101, MY_ADDR, 1'b0}, ak);
        for (int i = 7; i >= 4; i--) send_bit(8'b10_000001 >> i);
        bus_start();
        send_byte({4'b0101, MY_ADDR, 1'b0}, ak);
        check(ak == 1'b1, "R9 new control ack", int'(ak), 1);
        bus_stop();
        check(wp(2) == 17, "R9 partial not committed", wp(2), 17);

        // R10 pull never changed while SCL high covered by assertion; R1 reset mid-transfer
        bus_start();
        send_byte({4'b0101, MY_ADDR, 1'b1}, ak);
        rst_n = 1'b0;
        waitc(3);
        for (int c = 0; c < 4; c++) check(wp(c) == 32, "R1 reset mid transfer", wp(c), 32);
        check(sda_pull == 1'b0, "R1 pull released", int'(sda_pull), 0);
        scl = 1'b1; sda_m = 1'b1;
        waitc(10);

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule